// File: doc/BRIEF.md
# DDR SDRAM Low-Power State Controller

This block sits between a set of control bits and the command and clock-enable pins of a DDR SDRAM. It takes the memory into self-refresh and back out, and it drops the clock-enable into power-down between access bursts. When self-refresh is requested it closes any open banks if needed, sends the self-refresh command and only then lowers CKE. A status output follows the real memory state rather than the control bits.

On the way out of self-refresh two programmable recovery timers start at the moment CKE rises. One gates every non-read command and the other gates reads. Access grants stay off until both timers have expired. A periodic auto-refresh timer runs only while software enables it outside self-refresh. A small command-request field lets software issue a single all-bank precharge or auto-refresh while the memory is awake. All outputs come from registers clocked by the memory clock, and the command bus carries NOP on every cycle in which CKE changes level.

Top module: `ddr_lp_ctrl`

## Requirements
- R1: After reset, cke_o is 1, cmd_o is NOP (00), sr_stat_o and rec_busy_o are 0, and acc_go_o is 1.
- R2: With ref_en_i and sr_req_i both 1, acc_req_i low and no banks pending, cmd_o shows SREF (11) one cycle later. CKE falls in the following cycle, with cmd_o back at NOP.
- R3: sr_stat_o rises in the same cycle that CKE falls after SREF and clears in the cycle that CKE rises on exit. Writing the control bits alone never changes it.
- R4: Self-refresh is left only when ref_en_i and sr_req_i are both 0. While either one is still 1, CKE stays low and sr_stat_o stays 1.
- R5: On self-refresh exit, nrd_ok_o goes high exactly trec_cfg_i cycles after the first CKE-high cycle and rd_ok_o exactly rrec_cfg_i cycles after it. rec_busy_o is 1 until both are high, and no command is issued while nrd_ok_o is low.
- R6: acc_go_o is 0 while rec_busy_o is 1, while pd_force_i is 1, while CKE is low or just woken, and in any cycle where the block itself drives a command.
- R7: A self-refresh request made while acc_req_i is high is held (cmd_o stays NOP, CKE high) until acc_req_i drops. SREF then follows one cycle later.
- R8: If pre_pend_i is 1 when self-refresh starts, cmd_o shows PREALL (01) for one cycle, then SREF, then CKE falls.
- R9: With pd_force_i set and no burst active, CKE falls one cycle later and stays low whatever acc_req_i does. When pd_force_i clears, CKE rises one cycle later and acc_go_o rises one cycle after that.
- R10: With pd_auto_i set, CKE falls one cycle after acc_req_i drops and rises one cycle after acc_req_i rises. acc_go_o follows one cycle after CKE rises.
- R11: cmd_o is NOP in every cycle in which cke_o differs from its previous value.
- R12: A one-cycle cmd_req_i of 01 gives PREALL and 10 gives REFA (10) on cmd_o two cycles later when idle, or later once nrd_ok_o is high. Codes 00 and 11 issue nothing, and a request made during self-refresh is discarded.
- R13: With ref_en_i 1 and sr_req_i 0, the first automatic REFA appears REF_INT+1 cycles after enabling and then every REF_INT cycles. The timer is cleared while disabled, in self-refresh, or during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_en_i | input | 1 | Refresh enable control bit |
| sr_req_i | input | 1 | Self-refresh mode control bit |
| pd_force_i | input | 1 | Forces CKE low when no burst is active |
| pd_auto_i | input | 1 | Automatic power-down between bursts |
| acc_req_i | input | 1 | Access sequencer wants or holds a burst |
| pre_pend_i | input | 1 | Banks are open and need precharge |
| cmd_req_i | input | 2 | Manual command request (01 PREALL, 10 REFA) |
| trec_cfg_i | input | CW | Non-read recovery cycles after exit |
| rrec_cfg_i | input | CW | Read recovery cycles after exit |
| cke_o | output | 1 | Clock enable pin |
| cmd_o | output | 2 | Command: 00 NOP, 01 PREALL, 10 REFA, 11 SREF |
| sr_stat_o | output | 1 | Memory is in self-refresh |
| acc_go_o | output | 1 | Access burst may proceed |
| nrd_ok_o | output | 1 | Non-read commands allowed |
| rd_ok_o | output | 1 | Read commands allowed |
| rec_busy_o | output | 1 | Exit recovery in progress |

## Verification
The embedded properties assume the sequencer lowers pre_pend_i once the precharge has been sent and that cmd_req_i is a single-cycle pulse. They also assume the recovery configuration stays steady while a recovery count is running. The stimulus changes each input only at the falling clock edge, holds the recovery values fixed across every exit, and pulses the manual request field for exactly one cycle. It lowers the pending-precharge flag right after the PREALL cycle is seen.

// File: rtl/ddr_lp_pkg.sv
package ddr_lp_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'b00,
      CMD_PALL = 2'b01,
      CMD_AREF = 2'b10,
      CMD_SREF = 2'b11
   } dcmd_e;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_PD    = 3'd1,
      ST_WAKE  = 3'd2,
      ST_SRPRE = 3'd3,
      ST_SRCMD = 3'd4,
      ST_SR    = 3'd5
   } lpst_e;

endpackage

// File: rtl/ddr_lp_rcv_timer.sv
module ddr_lp_rcv_timer #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] cfg_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= cfg_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R5
   rcv_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R5
   rcv_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cnt_q == $past(cfg_i)));

endmodule

// File: rtl/ddr_lp_ref_timer.sv
module ddr_lp_ref_timer #(
   parameter int INTV = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic clr_i,
   output logic due_o
);

   localparam int RW = (INTV > 2) ? $clog2(INTV) : 1;
   localparam logic [RW-1:0] LAST = RW'(INTV - 1);

   logic [RW-1:0] cnt_q;
   logic          due_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         due_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q <= '0;
         due_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         due_q <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (clr_i)
            due_q <= 1'b0;
      end
   end

   assign due_o = due_q;

   // R13
   ref_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !due_o);

endmodule

// File: rtl/ddr_lp_man_cmd.sv
module ddr_lp_man_cmd
   import ddr_lp_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] req_i,
   input  logic       accept_ok_i,
   input  logic       take_i,
   output logic       pend_o,
   output dcmd_e      kind_o
);

   logic  pend_q;
   dcmd_e kind_q;
   logic  valid_code;
   dcmd_e code_cmd;

   always_comb begin
      valid_code = 1'b0;
      code_cmd   = CMD_NOP;
      case (req_i)
         2'b01: begin valid_code = 1'b1; code_cmd = CMD_PALL; end
         2'b10: begin valid_code = 1'b1; code_cmd = CMD_AREF; end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         kind_q <= CMD_NOP;
      end else if (take_i) begin
         pend_q <= 1'b0;
         kind_q <= CMD_NOP;
      end else if (!pend_q && valid_code && accept_ok_i) begin
         pend_q <= 1'b1;
         kind_q <= code_cmd;
      end
   end

   assign pend_o = pend_q;
   assign kind_o = kind_q;

   // R12
   man_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q |-> (kind_q == CMD_PALL || kind_q == CMD_AREF));

endmodule

// File: rtl/ddr_lp_ctrl.sv
module ddr_lp_ctrl
   import ddr_lp_pkg::*;
#(
   parameter int CW      = 8,
   parameter int REF_INT = 64,
   parameter bit REF_EN  = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          ref_en_i,
   input  logic          sr_req_i,
   input  logic          pd_force_i,
   input  logic          pd_auto_i,
   input  logic          acc_req_i,
   input  logic          pre_pend_i,
   input  logic [1:0]    cmd_req_i,
   input  logic [CW-1:0] trec_cfg_i,
   input  logic [CW-1:0] rrec_cfg_i,
   output logic          cke_o,
   output logic [1:0]    cmd_o,
   output logic          sr_stat_o,
   output logic          acc_go_o,
   output logic          nrd_ok_o,
   output logic          rd_ok_o,
   output logic          rec_busy_o
);

   localparam int NTMR = 2;

   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("ddr_lp_ctrl: CW must lie in 2..16");
   end
   if (REF_INT < 4) begin : g_bad_ref
      $error("ddr_lp_ctrl: REF_INT must be at least 4");
   end

   lpst_e st_q, st_d;
   logic  cke_q, cke_d;
   dcmd_e cmd_q, cmd_d;

   logic  sr_want, sr_leave;
   logic  man_pend, man_take, man_ok;
   dcmd_e man_kind;
   logic  ref_due, ref_clr, ref_run;
   logic  rec_load;
   logic  nr_ok, rd_ok, busy;

   logic [CW-1:0] tcfg [NTMR];
   logic          tzero [NTMR];

   assign sr_want  = ref_en_i && sr_req_i;
   assign sr_leave = !ref_en_i && !sr_req_i;

   // recovery timers: index 0 gates non-read commands, index 1 gates reads
   assign tcfg[0] = trec_cfg_i;
   assign tcfg[1] = rrec_cfg_i;

   for (genvar g = 0; g < NTMR; g++) begin : g_rcv
      ddr_lp_rcv_timer #(.CW(CW)) tmr_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (rec_load),
         .cfg_i  (tcfg[g]),
         .zero_o (tzero[g])
      );
   end

   assign nr_ok = tzero[0];
   assign rd_ok = tzero[1];
   assign busy  = !(nr_ok && rd_ok);

   // periodic refresh timer, optional
   assign ref_run = ref_en_i && !sr_req_i && !busy &&
                    (st_q == ST_RUN || st_q == ST_PD || st_q == ST_WAKE);

   if (REF_EN) begin : g_ref
      ddr_lp_ref_timer #(.INTV(REF_INT)) ref_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (ref_run),
         .clr_i  (ref_clr),
         .due_o  (ref_due)
      );
   end else begin : g_noref
      logic unused_ref;
      assign unused_ref = ref_clr ^ ref_run;
      assign ref_due    = 1'b0;
   end

   // manual command request holder
   assign man_ok = !sr_want &&
                   (st_q == ST_RUN || st_q == ST_PD || st_q == ST_WAKE);

   ddr_lp_man_cmd man_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (cmd_req_i),
      .accept_ok_i (man_ok),
      .take_i      (man_take),
      .pend_o      (man_pend),
      .kind_o      (man_kind)
   );

   // state sequencing
   always_comb begin
      st_d     = st_q;
      cke_d    = cke_q;
      cmd_d    = CMD_NOP;
      man_take = 1'b0;
      ref_clr  = 1'b0;
      case (st_q)
         ST_RUN: begin
            if (!acc_req_i && nr_ok) begin
               if (sr_want) begin
                  if (pre_pend_i) begin
                     st_d  = ST_SRPRE;
                     cmd_d = CMD_PALL;
                  end else begin
                     st_d  = ST_SRCMD;
                     cmd_d = CMD_SREF;
                  end
               end else if (man_pend) begin
                  cmd_d    = man_kind;
                  man_take = 1'b1;
               end else if (ref_due) begin
                  cmd_d   = CMD_AREF;
                  ref_clr = 1'b1;
               end else if ((pd_force_i || pd_auto_i) && !busy) begin
                  st_d  = ST_PD;
                  cke_d = 1'b0;
               end
            end
         end
         ST_PD: begin
            if (!pd_force_i && (acc_req_i || !pd_auto_i || sr_want ||
                                man_pend || ref_due)) begin
               st_d  = ST_WAKE;
               cke_d = 1'b1;
            end
         end
         ST_WAKE: st_d = ST_RUN;
         ST_SRPRE: begin
            st_d  = ST_SRCMD;
            cmd_d = CMD_SREF;
         end
         ST_SRCMD: begin
            st_d  = ST_SR;
            cke_d = 1'b0;
         end
         ST_SR: begin
            if (sr_leave) begin
               st_d  = ST_WAKE;
               cke_d = 1'b1;
            end
         end
         default: begin
            st_d  = ST_RUN;
            cke_d = 1'b1;
         end
      endcase
   end

   assign rec_load = (st_q == ST_SR) && (st_d == ST_WAKE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q  <= ST_RUN;
         cke_q <= 1'b1;
         cmd_q <= CMD_NOP;
      end else begin
         st_q  <= st_d;
         cke_q <= cke_d;
         cmd_q <= cmd_d;
      end
   end

   assign cke_o      = cke_q;
   assign cmd_o      = cmd_q;
   assign sr_stat_o  = (st_q == ST_SR);
   assign nrd_ok_o   = nr_ok;
   assign rd_ok_o    = rd_ok;
   assign rec_busy_o = busy;
   assign acc_go_o   = (st_q == ST_RUN) && !busy && !pd_force_i &&
                       (cmd_q == CMD_NOP);

   // R11
   cke_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cke_q != $past(cke_q)) |-> (cmd_q == CMD_NOP));

   // R3
   sr_stat_cke_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sr_stat_o |-> !cke_o);

   // R2
   sref_then_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == CMD_SREF) |=> (!cke_q && sr_stat_o));

   // R6
   grant_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_go_o |-> (cke_o && !rec_busy_o));

   // R5
   cmd_after_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q != CMD_NOP) |-> $past(nrd_ok_o));

   // R4
   sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_SR && (ref_en_i || sr_req_i)) |=> (st_q == ST_SR));

endmodule

// File: tb/ddr_lp_ctrl_tb.sv
module ddr_lp_ctrl_tb_top;

   localparam int CW      = 8;
   localparam int REF_INT = 16;
   localparam logic [1:0] C_NOP  = 2'b00;
   localparam logic [1:0] C_PALL = 2'b01;
   localparam logic [1:0] C_AREF = 2'b10;
   localparam logic [1:0] C_SREF = 2'b11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_en = 1'b0, sr_req = 1'b0, pd_force = 1'b0, pd_auto = 1'b0;
   logic          acc_req = 1'b0, pre_pend = 1'b0;
   logic [1:0]    cmd_req = 2'b00;
   logic [CW-1:0] trec = 8'd5, rrec = 8'd9;
   logic          cke, sr_stat, acc_go, nrd_ok, rd_ok, busy;
   logic [1:0]    cmd;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ddr_lp_ctrl #(.CW(CW), .REF_INT(REF_INT), .REF_EN(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .sr_req_i(sr_req),
      .pd_force_i(pd_force), .pd_auto_i(pd_auto), .acc_req_i(acc_req),
      .pre_pend_i(pre_pend), .cmd_req_i(cmd_req), .trec_cfg_i(trec),
      .rrec_cfg_i(rrec), .cke_o(cke), .cmd_o(cmd), .sr_stat_o(sr_stat),
      .acc_go_o(acc_go), .nrd_ok_o(nrd_ok), .rd_ok_o(rd_ok), .rec_busy_o(busy));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 cke", cke, 1);
      chk("R1 cmd", cmd, C_NOP);
      chk("R1 sr_stat", sr_stat, 0);
      chk("R1 busy", busy, 0);
      chk("R1 acc_go", acc_go, 1);
   endtask

   task automatic t_manual();
      cmd_req = 2'b01; tick(); cmd_req = 2'b00;
      chk("R12 pall early", cmd, C_NOP);
      tick(); chk("R12 pall issue", cmd, C_PALL);
      chk("R6 no grant during cmd", acc_go, 0);
      tick(); chk("R12 pall single", cmd, C_NOP);
      cmd_req = 2'b10; tick(); cmd_req = 2'b00;
      tick(); chk("R12 aref issue", cmd, C_AREF);
      tick(); chk("R12 aref single", cmd, C_NOP);
      cmd_req = 2'b11; tick(); cmd_req = 2'b00;
      for (int i = 0; i < 4; i++) begin
         chk("R12 code 11 ignored", cmd, C_NOP);
         tick();
      end
   endtask

   task automatic t_refresh();
      int first = -1, last = -1, hits = 0;
      ref_en = 1'b1;
      for (int i = 1; i <= 3 * REF_INT + 2; i++) begin
         tick();
         if (cmd == C_AREF) begin
            if (first < 0) first = i;
            else chk("R13 interval", i - last, REF_INT);
            last = i;
            hits++;
         end
      end
      chk("R13 first refresh", first, REF_INT + 1);
      chk("R13 refresh count", hits, 3);
      ref_en = 1'b0;
      tick(); tick();
   endtask

   task automatic t_auto_pd();
      pd_auto = 1'b1; tick();
      chk("R10 cke low idle", cke, 0);
      chk("R11 nop on fall", cmd, C_NOP);
      chk("R6 no grant in pd", acc_go, 0);
      tick(); chk("R10 cke stays low", cke, 0);
      acc_req = 1'b1; tick();
      chk("R10 cke rise", cke, 1);
      chk("R11 nop on rise", cmd, C_NOP);
      chk("R10 grant late", acc_go, 0);
      tick(); chk("R10 grant", acc_go, 1);
      tick(); chk("R10 cke held in burst", cke, 1);
      acc_req = 1'b0; tick();
      chk("R10 cke low after burst", cke, 0);
      pd_auto = 1'b0; tick();
      chk("R10 wake on disable", cke, 1);
      tick();
   endtask

   task automatic t_forced_pd();
      pd_force = 1'b1; tick();
      chk("R9 cke low", cke, 0);
      acc_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R9 cke held low", cke, 0);
         chk("R6 stalled", acc_go, 0);
      end
      pd_force = 1'b0; tick();
      chk("R9 cke rise", cke, 1);
      chk("R9 grant late", acc_go, 0);
      tick(); chk("R9 grant", acc_go, 1);
   endtask

   task automatic t_sr_in_burst();
      ref_en = 1'b1; sr_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R7 held cmd", cmd, C_NOP);
         chk("R7 held cke", cke, 1);
         chk("R3 stat not on write", sr_stat, 0);
      end
      acc_req = 1'b0; tick();
      chk("R2 sref", cmd, C_SREF);
      chk("R2 cke high at sref", cke, 1);
      chk("R3 stat before cke", sr_stat, 0);
      tick();
      chk("R2 cke low", cke, 0);
      chk("R2 nop at fall", cmd, C_NOP);
      chk("R3 stat set", sr_stat, 1);
   endtask

   task automatic t_partial_and_exit();
      sr_req = 1'b0;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R4 stays in sr", sr_stat, 1);
         chk("R4 cke low", cke, 0);
      end
      ref_en = 1'b0;
      for (int i = 0; i <= 12; i++) begin
         tick();
         if (i == 0) begin
            chk("R3 stat clear on rise", sr_stat, 0);
            chk("R3 cke high", cke, 1);
            chk("R11 nop on exit", cmd, C_NOP);
         end
         chk("R5 nrd_ok", nrd_ok, (i >= 5) ? 1 : 0);
         chk("R5 rd_ok", rd_ok, (i >= 9) ? 1 : 0);
         chk("R5 busy", busy, (i < 9) ? 1 : 0);
         chk("R6 grant after rec", acc_go, (i >= 9) ? 1 : 0);
         chk("R12 gated manual", cmd, (i == 6) ? C_AREF : C_NOP);
         cmd_req = (i == 0) ? 2'b10 : 2'b00;
      end
   endtask

   task automatic t_sr_precharge();
      int seen = 0;
      pre_pend = 1'b1; ref_en = 1'b1; sr_req = 1'b1;
      tick();
      chk("R8 precharge first", cmd, C_PALL);
      chk("R8 cke high", cke, 1);
      pre_pend = 1'b0;
      tick(); chk("R8 sref second", cmd, C_SREF);
      tick(); chk("R8 cke low", cke, 0);
      chk("R8 stat", sr_stat, 1);
      cmd_req = 2'b10; tick(); cmd_req = 2'b00;
      tick();
      trec = 8'd2; rrec = 8'd3;
      ref_en = 1'b0; sr_req = 1'b0;
      for (int i = 0; i < 8; i++) begin
         tick();
         if (cmd != C_NOP) seen++;
      end
      chk("R12 discarded in sr", seen, 0);
      chk("R5 recovered", busy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_manual();
      t_refresh();
      t_auto_pd();
      t_forced_pd();
      t_sr_in_burst();
      t_partial_and_exit();
      t_sr_precharge();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule